// File: doc/BRIEF.md
# BT.656 Ancillary Packet and Timing Code Inserter

This block sits on an 8-bit 4:2:2 byte stream and replaces bytes with BT.656 timing reference codes and ancillary data packets on request. Upstream timing logic pulses a request at the point on the line where a start-of-active-video or end-of-active-video code belongs, giving the field and vertical-blanking state. Within horizontal blanking it pulses a packet request for a captured VBI payload: captions, widescreen signalling, teletext or real-time control data. The payload sits in an external buffer that the block reads one word per byte slot. When no code or packet is in progress, the incoming byte is passed through.

Every output byte is registered, so the output lags the inputs by one clock. A timing code takes four byte slots. A packet takes six byte slots plus one per user word: three preamble bytes, a data identifier, a word count, the user words and a checksum. Each service has its own enable bit. A request for a disabled service produces no packet.

Top module: `vid_anc_inserter`

## Requirements
- R1: With no sequence in progress and no accepted request, `dout` equals the `pix_in` value sampled at the previous rising clock edge. While `rst` is high, `dout` is 0.
- R2: When `code_go` is accepted, the next four output bytes are 0xFF, 0x00, 0x00, XY.
- R3: The XY byte holds a 1 in bit 7, F in bit 6, V in bit 5 and H in bit 4, where H=1 marks end of active video and H=0 marks start. Its protection bits are bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H. F, V and H are sampled with the request.
- R4: When `anc_go` is accepted, the next N+6 output bytes are 0x00, 0xFF, 0xFF, the ID word, the count word, N user words and the checksum word, where N = `anc_len` (0 to 63).
- R5: The ID word carries `anc_did[6:0]` in bits 6..0, and the count word carries N in bits 6..0. In both words bit 7 is the inverse of bit 6.
- R6: The checksum word carries in bits 6..0 the sum of bits 6..0 of the ID word, the count word and every user word, taken modulo 128 (starting from zero, carries dropped). Its bit 7 is the inverse of bit 6.
- R7: User word k carries the buffer word at address k. With `pay_narrow`=0 it is the whole 8-bit word. With `pay_narrow`=1 it is {2'b10, word[5:0]}: payload in bits 5..0, bit 6 = 0 and bit 7 = 1.
- R8: `anc_go` is accepted only if `svc_en[anc_svc]` is 1 (service 0 captions, 1 WSS, 2 teletext, 3 real-time control). Otherwise the stream keeps passing `pix_in` through.
- R9: `code_go` wins over `anc_go` when both arrive in the same idle cycle. Both requests are ignored while a code or packet is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 8 | Incoming video byte |
| code_go | input | 1 | Request for a timing reference code |
| code_h | input | 1 | H value: 1 end of active video, 0 start |
| fld | input | 1 | F value (field) |
| vblank | input | 1 | V value, 1 in vertical blanking |
| anc_go | input | 1 | Request for an ancillary packet |
| anc_svc | input | 2 | Service selector for the request |
| svc_en | input | 4 | Per-service enable bits |
| anc_len | input | 6 | Number of user words |
| anc_did | input | 7 | Data identifier, bits 6..0 |
| pay_narrow | input | 1 | 1: six useful bits per user word |
| rd_addr | output | 6 | Payload buffer read address |
| rd_data | input | 8 | Payload word at `rd_addr`, same cycle |
| dout | output | 8 | Output byte stream |

## Verification
The assertions assume that the payload buffer answers `rd_addr` combinationally in the same cycle. They also assume that length, identifier and mode are presented together with the request pulse. The bench models the buffer as a combinational function of the address and a seed, and holds the request fields steady for the length of each packet. It also raises both request lines in the middle of sequences to confirm that they are ignored. Its sweeps cover every F/V/H combination, every service and enable mask, every length from 0 to 63 in both payload modes, and all 256 pass-through values.

// File: rtl/vid_anc_pkg.sv
package vid_anc_pkg;

    typedef enum logic [2:0] {
        K_PASS, K_FF, K_00, K_XY, K_DID, K_DC, K_USR, K_CS
    } byte_kind_e;

    typedef enum logic [1:0] {
        S_IDLE, S_TRC, S_ANC
    } seq_mode_e;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } fvh_t;

    function automatic logic [7:0] xy_code(input fvh_t c);
        return {1'b1, c.f, c.v, c.h,
                c.v ^ c.h, c.f ^ c.h, c.f ^ c.v, c.f ^ c.v ^ c.h};
    endfunction

    function automatic logic [7:0] hdr_word(input logic [6:0] w);
        return {~w[6], w};
    endfunction

endpackage

// File: rtl/anc_seq.sv
module anc_seq
    import vid_anc_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int NSVC  = 4,
    parameter int SVC_W = $clog2(NSVC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             code_go,
    input  logic             code_h,
    input  logic             fld,
    input  logic             vblank,
    input  logic             anc_go,
    input  logic [SVC_W-1:0] anc_svc,
    input  logic [NSVC-1:0]  svc_en,
    input  logic [LEN_W-1:0] anc_len,
    input  logic [6:0]       anc_did,
    input  logic             pay_narrow,
    output byte_kind_e       kind,
    output fvh_t             fvh_q,
    output logic [6:0]       did_q,
    output logic [LEN_W-1:0] len_q,
    output logic             narrow_q,
    output logic [LEN_W-1:0] usr_idx
);
    localparam int POS_W = LEN_W + 2;
    localparam logic [POS_W-1:0] HDR_BYTES = POS_W'(5);

    seq_mode_e        mode, nxt_mode;
    logic [POS_W-1:0] pos, nxt_pos, pos_last;
    logic             start_trc, start_anc;

    assign pos_last = POS_W'(len_q) + HDR_BYTES;
    assign usr_idx  = LEN_W'(pos - HDR_BYTES);

    always_comb begin
        kind      = K_PASS;
        nxt_mode  = mode;
        nxt_pos   = pos + POS_W'(1);
        start_trc = 1'b0;
        start_anc = 1'b0;
        case (mode)
            S_IDLE: begin
                nxt_pos = '0;
                if (code_go) begin
                    kind      = K_FF;
                    nxt_mode  = S_TRC;
                    nxt_pos   = POS_W'(1);
                    start_trc = 1'b1;
                end else if (anc_go && svc_en[anc_svc]) begin
                    kind      = K_00;
                    nxt_mode  = S_ANC;
                    nxt_pos   = POS_W'(1);
                    start_anc = 1'b1;
                end
            end
            S_TRC: begin
                if (pos == POS_W'(3)) begin
                    kind     = K_XY;
                    nxt_mode = S_IDLE;
                    nxt_pos  = '0;
                end else begin
                    kind = K_00;
                end
            end
            S_ANC: begin
                if (pos <= POS_W'(2))      kind = K_FF;
                else if (pos == POS_W'(3)) kind = K_DID;
                else if (pos == POS_W'(4)) kind = K_DC;
                else if (pos == pos_last) begin
                    kind     = K_CS;
                    nxt_mode = S_IDLE;
                    nxt_pos  = '0;
                end else begin
                    kind = K_USR;
                end
            end
            default: begin
                nxt_mode = S_IDLE;
                nxt_pos  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= S_IDLE;
            pos      <= '0;
            fvh_q    <= '0;
            did_q    <= '0;
            len_q    <= '0;
            narrow_q <= 1'b0;
        end else begin
            mode <= nxt_mode;
            pos  <= nxt_pos;
            if (start_trc) fvh_q <= '{f: fld, v: vblank, h: code_h};
            if (start_anc) begin
                did_q    <= anc_did;
                len_q    <= anc_len;
                narrow_q <= pay_narrow;
            end
        end
    end

    AST_TRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == S_TRC && pos != POS_W'(3)) |=> mode == S_TRC); // R9

    AST_ANC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == S_ANC && pos != pos_last) |=> mode == S_ANC); // R9

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode == S_IDLE && !code_go && anc_go && !svc_en[anc_svc]) |=> mode == S_IDLE); // R8

    AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
        mode == S_ANC |-> pos <= pos_last); // R4

endmodule

// File: rtl/anc_cksum.sv
module anc_cksum
    import vid_anc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  byte_kind_e kind,
    input  logic [6:0] word7,
    output logic [6:0] sum
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else begin
            case (kind)
                K_DID:        sum <= word7;
                K_DC, K_USR:  sum <= sum + word7;
                default:      sum <= sum;
            endcase
        end
    end
endmodule

// File: rtl/vid_anc_inserter.sv
module vid_anc_inserter
    import vid_anc_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int NSVC  = 4,
    parameter int SVC_W = $clog2(NSVC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       pix_in,
    input  logic             code_go,
    input  logic             code_h,
    input  logic             fld,
    input  logic             vblank,
    input  logic             anc_go,
    input  logic [SVC_W-1:0] anc_svc,
    input  logic [NSVC-1:0]  svc_en,
    input  logic [LEN_W-1:0] anc_len,
    input  logic [6:0]       anc_did,
    input  logic             pay_narrow,
    output logic [LEN_W-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    output logic [7:0]       dout
);
    byte_kind_e       kind, kind_q;
    fvh_t             fvh_q;
    logic [6:0]       did_q, sum;
    logic [LEN_W-1:0] len_q;
    logic             narrow_q;
    logic [7:0]       byte_d;

    anc_seq #(.LEN_W(LEN_W), .NSVC(NSVC), .SVC_W(SVC_W)) i_seq (
        .clk, .rst, .code_go, .code_h, .fld, .vblank, .anc_go, .anc_svc,
        .svc_en, .anc_len, .anc_did, .pay_narrow,
        .kind, .fvh_q, .did_q, .len_q, .narrow_q, .usr_idx(rd_addr)
    );

    always_comb begin
        case (kind)
            K_FF:    byte_d = 8'hFF;
            K_00:    byte_d = 8'h00;
            K_XY:    byte_d = xy_code(fvh_q);
            K_DID:   byte_d = hdr_word(did_q);
            K_DC:    byte_d = hdr_word(7'(len_q));
            K_USR:   byte_d = narrow_q ? {2'b10, rd_data[5:0]} : rd_data;
            K_CS:    byte_d = hdr_word(sum);
            default: byte_d = pix_in;
        endcase
    end

    anc_cksum i_cksum (
        .clk, .rst, .kind, .word7(byte_d[6:0]), .sum
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= '0;
            kind_q <= K_PASS;
        end else begin
            dout   <= byte_d;
            kind_q <= kind;
        end
    end

    AST_HDR_INV: assert property (@(posedge clk) disable iff (rst)
        (kind_q == K_DID || kind_q == K_DC || kind_q == K_CS) |-> dout[7] != dout[6]); // R5

    AST_XY_PROT: assert property (@(posedge clk) disable iff (rst)
        kind_q == K_XY |-> (dout[7] && dout[3:0] == {dout[5] ^ dout[4], dout[6] ^ dout[4],
                                                   dout[6] ^ dout[5], ^dout[6:4]})); // R3

    AST_NARROW_TOP: assert property (@(posedge clk) disable iff (rst)
        (kind_q == K_USR && narrow_q) |-> dout[7:6] == 2'b10); // R7

endmodule

// File: tb/test_vid_anc_inserter.sv
module test_vid_anc_inserter;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix_in = 8'h00;
    logic       code_go = 1'b0, code_h = 1'b0, fld = 1'b0, vblank = 1'b0;
    logic       anc_go = 1'b0;
    logic [1:0] anc_svc = '0;
    logic [3:0] svc_en = '0;
    logic [5:0] anc_len = '0;
    logic [6:0] anc_did = '0;
    logic       pay_narrow = 1'b0;
    logic [5:0] rd_addr;
    logic [7:0] rd_data;
    logic [7:0] dout;
    int         seed = 0;
    int         total = 0, bad = 0;
    bit         done = 0;

    vid_anc_inserter i_vid_anc_inserter (
        .clk, .rst, .pix_in, .code_go, .code_h, .fld, .vblank, .anc_go,
        .anc_svc, .svc_en, .anc_len, .anc_did, .pay_narrow,
        .rd_addr, .rd_data, .dout
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pay(input int a, input int s);
        return 8'((a * 29) + (s * 7) + 3);
    endfunction

    always_comb rd_data = pay(int'(rd_addr), seed);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] xy_exp(input bit f, input bit v, input bit h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] hdr(input int x);
        logic [6:0] w;
        w = 7'(x);
        return {~w[6], w};
    endfunction

    // R2 R3 R9: timing code, optional poke of both requests mid-sequence
    task automatic run_trc(input bit f, input bit v, input bit h, input bit poke);
        logic [7:0] exp [4];
        exp[0] = 8'hFF; exp[1] = 8'h00; exp[2] = 8'h00; exp[3] = xy_exp(f, v, h);
        @(negedge clk);
        code_go = 1'b1; code_h = h; fld = f; vblank = v;
        anc_go = poke; svc_en = 4'hF;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            code_go = poke && (j < 3); anc_go = poke && (j < 3);
            code_h = ~h; fld = ~f; vblank = ~v;
            pix_in = 8'hA5;
            chk(j == 3 ? "R3" : (poke ? "R9" : "R2"), dout, exp[j]);
        end
        @(negedge clk);
        chk("R1", dout, 8'hA5);
    endtask

    // R4 R5 R6 R7 R8 R9: ancillary packet
    task automatic run_pkt(input int svc, input int en, input int len, input bit nar,
                           input int did, input int s, input bit poke);
        logic [7:0] exp [70];
        int         n, sum;
        logic [7:0] w;
        seed = s;
        n = len + 6;
        exp[0] = 8'h00; exp[1] = 8'hFF; exp[2] = 8'hFF;
        exp[3] = hdr(did); exp[4] = hdr(len);
        sum = (did & 127) + (len & 127);
        for (int k = 0; k < len; k++) begin
            w = pay(k, s);
            if (nar) w = {2'b10, w[5:0]};
            exp[5 + k] = w;
            sum += int'(w[6:0]);
        end
        exp[5 + len] = hdr(sum & 127);
        @(negedge clk);
        anc_go = 1'b1; anc_svc = 2'(svc); svc_en = 4'(en); anc_len = 6'(len);
        anc_did = 7'(did); pay_narrow = nar; pix_in = 8'h3C;
        if (en[svc]) begin
            for (int j = 0; j < n; j++) begin
                @(negedge clk);
                anc_go = poke && (j < n - 1); code_go = poke && (j < n - 1);
                pix_in = 8'hA5;
                if (j < 3)           chk(poke ? "R9" : "R4", dout, exp[j]);
                else if (j < 5)      chk("R5", dout, exp[j]);
                else if (j < n - 1)  chk("R7", dout, exp[j]);
                else                 chk("R6", dout, exp[j]);
            end
            @(negedge clk);
            chk("R1", dout, 8'hA5);
        end else begin
            @(negedge clk);
            anc_go = 1'b0; pix_in = 8'h5A;
            chk("R8", dout, 8'h3C);
            @(negedge clk);
            chk("R8", dout, 8'h5A);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", dout, 8'h00);
        rst = 1'b0;
        // R1 pass-through of every byte value
        for (int v = 0; v < 256; v++) begin
            @(negedge clk);
            if (v > 0) chk("R1", dout, 8'(v - 1));
            pix_in = 8'(v);
        end
        @(negedge clk);
        chk("R1", dout, 8'hFF);
        // R2 R3 every F/V/H combination
        for (int c = 0; c < 8; c++) run_trc(c[2], c[1], c[0], 1'b0);
        // R9 requests during a code are ignored
        run_trc(1'b1, 1'b0, 1'b1, 1'b1);
        // R9 same-cycle priority: code wins over an enabled packet
        run_trc(1'b0, 1'b1, 1'b0, 1'b1);
        // R8 every service against every enable mask
        for (int svc = 0; svc < 4; svc++)
            for (int en = 0; en < 16; en++)
                run_pkt(svc, en, 1 + svc, en[0], 16 * svc + en, en, 1'b0);
        // R4 R6 R7 every length in both payload modes
        for (int len = 0; len < 64; len++)
            for (int nar = 0; nar < 2; nar++)
                run_pkt(len % 4, 15, len, nar[0], (len * 5 + 64 * nar) & 127, len + nar, 1'b0);
        // R9 requests during a packet are ignored
        run_pkt(2, 15, 3, 1'b0, 100, 9, 1'b1);
        run_pkt(1, 15, 0, 1'b1, 63, 4, 1'b1);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule